// File: doc/BRIEF.md
# Free-run/restart compare timer

This block is an up-counting timer with a word-addressed register bus. The bus has an address, a write strobe, write data and registered read data. One of two tick-enable inputs drives the count rate. A clock-source field in the control register picks the input, and a 12-bit prescaler divides it. One compare channel and a full-range rollover event set sticky status flags. Software clears a flag by writing 1 to its bit. A single interrupt line is formed from the flags, their enable bits and the timer enable.

There are two counting modes. In restart mode the counter goes back to zero on the count after it matches the compare value, so it forms a periodic timebase. In free-run mode it counts through the compare value, flagging the match, and wraps from all ones to zero, flagging the rollover. When the timer is enabled, an enable-mode bit chooses whether the counter restarts from zero or resumes from its held value. A self-clearing soft-reset bit returns the block to its idle state but keeps part of the control register.

The counter width is a parameter (default 32 bits). All register fields that hold a count follow that width.

Top module: `frt_timer`

## Requirements
- R1: After hardware reset (rst high on a clock edge), the registers read as follows. Control, prescaler, status, interrupt enable and counter read 0. The compare value reads all ones of the counter width. irq is 0.
- R2: Registers sit at these word addresses: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 compare, 9 counter. The counter is read only. bus_rdata shows, one clock after the address is presented, the value the register held before that edge. Every other address reads 0, and writes to it or to address 9 change nothing.
- R3: The control bits are: bit 0 enable, bit 1 enable-mode, bits 2, 3 and 4 stored mode bits, bits 8:6 clock source, bit 9 free-run (1) or restart (0), bit 15 soft reset. Bits 15:10 always read 0. The other bits read back as written.
- R4: While enable is 1, the source codes act as follows. Codes 3'b001 and 3'b010 count tick_main. Code 3'b100 counts tick_lf. Every other code stops counting. A tick is a clock cycle with the selected input high.
- R5: The prescaler register keeps bits 11:0. After the counter is restarted, it advances once for every (prescaler+1) selected ticks.
- R6: In restart mode, a count taken while the counter equals the compare value returns the counter to 0 and sets status bit 0.
- R7: A write to the compare register in restart mode clears the counter.
- R8: In free-run mode, a count taken at the compare value moves on to compare+1 and sets status bit 0. A count taken at all ones wraps to 0 and sets status bit 5.
- R9: Writing 1 to status bit 0 or bit 5 clears that flag, and writing 0 leaves it unchanged. A flag set by a count in the same cycle as a clearing write stays set.
- R10: The interrupt-enable register keeps bits 5:0. One clock after the state changes, irq equals enable AND a nonzero value of (status AND interrupt-enable AND 6'b100001).
- R11: While enable is 0, the counter holds. A write that takes enable from 0 to 1 with enable-mode 1 restarts the counter and prescaler from 0. With enable-mode 0, counting resumes from the held value.
- R12: A control write with bit 15 set ignores the rest of the word. It clears control bits 0, 2, 3 and 4 and keeps the other control bits. It clears status, prescaler, interrupt enable and counter, and sets the compare value to all ones. Bit 15 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_main | input | 1 | Main count-enable input |
| tick_lf | input | 1 | Low-frequency count-enable input |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a count event that lands in the same clock cycle as a write-1-to-clear of the flag it sets. To get there, the bench first uses restart mode and a small compare value to park the counter at the compare value. It then raises tick_main and the status write together on one falling edge. A flag that ends up cleared, or a counter that does not return to zero, shows the wrong priority. Rollover needs a full pass over the counter range. The bench therefore runs with an 8-bit counter, so the all-ones wrap and its flag are reached after 256 ticks.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int BUS_W = 32;

  localparam int OFS_CTRL = 0;
  localparam int OFS_PRE  = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_IE   = 3;
  localparam int OFS_CMP  = 4;
  localparam int OFS_CNT  = 9;

  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_SRCLO = 6;
  localparam int B_FRR   = 9;
  localparam int B_SWR   = 15;

  localparam int STAT_CMP_BIT = 0;
  localparam int STAT_ROV_BIT = 5;
  localparam int IE_W         = 6;

  localparam logic [BUS_W-1:0] CTRL_KEEP = 32'hFFFF_03FF;
  localparam logic [BUS_W-1:0] SOFT_CLR  = 32'h0000_001D;
  localparam logic [IE_W-1:0]  IRQ_MASK  = 6'b100001;

  typedef enum logic [2:0] {
    SRC_OFF  = 3'b000,
    SRC_MAIN = 3'b001,
    SRC_HI   = 3'b010,
    SRC_LF   = 3'b100
  } src_e;
endpackage

// File: rtl/frt_tick_gen.sv
module frt_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [2:0]       src,
  input  logic [PRE_W-1:0] prescale,
  input  logic             tick_main,
  input  logic             tick_lf,
  output logic             step
);
  import frt_pkg::*;

  logic             tsel;
  logic [PRE_W-1:0] pre_cnt;
  logic             pre_done;

  always_comb begin
    case (src)
      SRC_MAIN, SRC_HI: tsel = tick_main;
      SRC_LF:           tsel = tick_lf;
      default:          tsel = 1'b0;
    endcase
  end

  assign pre_done = (pre_cnt >= prescale);

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      pre_cnt <= '0;
    end else if (tsel) begin
      if (pre_done) pre_cnt <= '0;
      else          pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign step = run & tsel & pre_done & ~clr;
endmodule

// File: rtl/frt_count_core.sv
module frt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             frr,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_evt,
  output logic             rov_evt
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic live;
  logic at_cmp;

  assign live    = step & ~clr;
  assign at_cmp  = (cnt == cmp);
  assign cmp_evt = live & at_cmp;
  assign rov_evt = live & (cnt == ALL1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (!frr && at_cmp) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_main,
  input  logic              tick_lf,
  output logic              irq
);
  import frt_pkg::*;

  localparam int NFLAG = 2;
  localparam logic [CNT_W-1:0] CMP_INIT = {CNT_W{1'b1}};

  logic [BUS_W-1:0] ctrl_q;
  logic [PRE_W-1:0] pre_q;
  logic [IE_W-1:0]  ie_q;
  logic [CNT_W-1:0] cmp_q;
  logic [NFLAG-1:0] stat_q;
  logic [NFLAG-1:0] flag_evt;
  logic [CNT_W-1:0] cnt_w;
  logic             step_w;
  logic             cmp_evt_w;
  logic             rov_evt_w;
  logic [31:0]      rdata_q;
  logic             irq_q;

  logic wr_ctrl, wr_pre, wr_stat, wr_ie, wr_cmp;
  logic soft_w, en_rise, restart_w, cnt_clr, tick_clr;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_pre  = bus_wr && (bus_addr == ADDR_W'(OFS_PRE));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(OFS_IE));
  assign wr_cmp  = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));

  assign soft_w    = wr_ctrl && bus_wdata[B_SWR];
  assign en_rise   = wr_ctrl && !bus_wdata[B_SWR] && bus_wdata[B_EN] && !ctrl_q[B_EN];
  assign restart_w = en_rise && bus_wdata[B_ENMOD];
  assign tick_clr  = soft_w || restart_w;
  assign cnt_clr   = tick_clr || (wr_cmp && !ctrl_q[B_FRR]);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (soft_w)  ctrl_q <= ctrl_q & ~SOFT_CLR;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_w) begin
      pre_q <= '0;
      ie_q  <= '0;
      cmp_q <= CMP_INIT;
    end else begin
      if (wr_pre) pre_q <= bus_wdata[PRE_W-1:0];
      if (wr_ie)  ie_q  <= bus_wdata[IE_W-1:0];
      if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
    end
  end

  frt_tick_gen #(.PRE_W(PRE_W)) tick_i (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q[B_EN]),
    .clr       (tick_clr),
    .src       (ctrl_q[B_SRCLO+2:B_SRCLO]),
    .prescale  (pre_q),
    .tick_main (tick_main),
    .tick_lf   (tick_lf),
    .step      (step_w)
  );

  frt_count_core #(.CNT_W(CNT_W)) core_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .step    (step_w),
    .frr     (ctrl_q[B_FRR]),
    .cmp     (cmp_q),
    .cnt     (cnt_w),
    .cmp_evt (cmp_evt_w),
    .rov_evt (rov_evt_w)
  );

  assign flag_evt = {rov_evt_w, cmp_evt_w};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int POS = (g == 0) ? STAT_CMP_BIT : STAT_ROV_BIT;
    always_ff @(posedge clk) begin
      if (rst || soft_w)
        stat_q[g] <= 1'b0;
      else if (flag_evt[g])
        stat_q[g] <= 1'b1;
      else if (wr_stat && bus_wdata[POS])
        stat_q[g] <= 1'b0;
    end
  end

  logic [IE_W-1:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[STAT_CMP_BIT] = stat_q[0];
    stat_word[STAT_ROV_BIT] = stat_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ctrl_q[B_EN] && (|(stat_word & ie_q & IRQ_MASK));
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): rd_mux = ctrl_q;
      ADDR_W'(OFS_PRE):  rd_mux[PRE_W-1:0] = pre_q;
      ADDR_W'(OFS_STAT): rd_mux[IE_W-1:0] = stat_word;
      ADDR_W'(OFS_IE):   rd_mux[IE_W-1:0] = ie_q;
      ADDR_W'(OFS_CMP):  rd_mux[CNT_W-1:0] = cmp_q;
      ADDR_W'(OFS_CNT):  rd_mux[CNT_W-1:0] = cnt_w;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [31:0]       ctrl_q,
  input logic              step_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [1:0]        stat_q
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic clr_wr, soft_wr;
  assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(2)) && bus_wdata[0];
  assign soft_wr = bus_wr && (bus_addr == ADDR_W'(0)) && bus_wdata[15];

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(0)) |-> (bus_rdata[15:10] == 6'd0)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q[0])); // R10

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !bus_wr) |=> $stable(cnt_w)); // R11

  AST_RESTART_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_w && !ctrl_q[9] && (cnt_w == cmp_q) && !bus_wr) |=> ((cnt_w == '0) && stat_q[0])); // R6

  AST_FREE_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
    (step_w && ctrl_q[9] && (cnt_w == ALL1) && !bus_wr) |=> ((cnt_w == '0) && stat_q[1])); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !clr_wr && !soft_wr) |=> stat_q[0]); // R9

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    soft_wr |=> ((cmp_q == ALL1) && (cnt_w == '0) && (stat_q == 2'b00) && !ctrl_q[0])); // R12
endmodule

bind frt_timer frt_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .step_w    (step_w),
  .cnt_w     (cnt_w),
  .cmp_q     (cmp_q),
  .stat_q    (stat_q)
);

// File: tb/frt_timer_tb_top.sv
`timescale 1ns/1ps
module frt_timer_tb_top;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 12;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              tick_main = 1'b0;
  logic              tick_lf = 1'b0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frt_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_main(tick_main), .tick_lf(tick_lf), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wr = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic rchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic ticks(input bit lf, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lf) tick_lf = 1'b1; else tick_main = 1'b1;
      @(negedge clk);
      tick_lf = 1'b0; tick_main = 1'b0;
    end
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    @(negedge clk);
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rchk("R1 ctrl", 0, 32'h0);
    rchk("R1 prescaler", 1, 32'h0);
    rchk("R1 status", 2, 32'h0);
    rchk("R1 irq enable", 3, 32'h0);
    rchk("R1 compare", 4, 32'h0000_00FF);
    rchk("R1 counter", 9, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2: unmapped addresses and read-only counter
    wr(5, 32'hDEAD_BEEF);
    rchk("R2 addr5", 5, 32'h0);
    wr(9, 32'h55);
    rchk("R2 counter read only", 9, 32'h0);
    rchk("R2 addr15", 15, 32'h0);
    rchk("R2 addr8", 8, 32'h0);

    // R3: control layout (source 7 keeps the counter stopped)
    wr(0, 32'hFFFF_7FFF);
    rchk("R3 ctrl readback", 0, 32'hFFFF_03FF);
    rchk("R4 code 7 no count", 9, 32'h0);
    wr(0, 32'h0);

    // R5: prescaler width and division sweep
    wr(1, 32'h0000_1FFF);
    rchk("R5 prescaler width", 1, 32'h0000_0FFF);
    for (int p = 0; p <= 6; p++) begin
      wr(0, 32'h0);
      wr(1, p);
      wr(0, 32'h243);
      ticks(0, 12);
      rchk($sformatf("R5 pre=%0d", p), 9, 12 / (p + 1));
    end
    wr(1, 32'd11);
    wr(0, 32'h0);
    wr(0, 32'h243);
    ticks(0, 11);
    rchk("R5 pre=11 before", 9, 32'd0);
    ticks(0, 1);
    rchk("R5 pre=11 after", 9, 32'd1);
    wr(1, 32'h0);

    // R4: clock source sweep
    for (int s = 0; s < 8; s++) begin
      logic [31:0] e;
      wr(0, 32'h0);
      wr(0, 32'h203 | (s << 6));
      ticks(0, 5);
      ticks(1, 3);
      e = (s == 1 || s == 2) ? 32'd5 : (s == 4) ? 32'd3 : 32'd0;
      rchk($sformatf("R4 src=%0d", s), 9, e);
    end

    // R7: compare write in restart mode clears counter
    wr(0, 32'h0);
    wr(0, 32'h243);
    ticks(0, 3);
    wr(0, 32'h043);
    rchk("R7 held before write", 9, 32'd3);
    wr(4, 32'd4);
    rchk("R7 cleared by compare write", 9, 32'd0);

    // R6: restart-mode sweep, period compare+1
    for (int k = 1; k <= 12; k++) begin
      ticks(0, 1);
      rchk($sformatf("R6 count k=%0d", k), 9, k % 5);
      if (k == 4) rchk("R6 no flag before match", 2, 32'h0);
      if (k == 5) rchk("R6 flag at match", 2, 32'h1);
    end

    // R9: write-1-to-clear and collision
    wr(2, 32'h0);
    rchk("R9 write 0 keeps flag", 2, 32'h1);
    wr(2, 32'h21);
    rchk("R9 write 1 clears flag", 2, 32'h0);
    ticks(0, 2);
    rchk("R9 parked at compare", 9, 32'd4);
    @(negedge clk);
    tick_main = 1'b1; bus_addr = ADDR_W'(2); bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    tick_main = 1'b0; bus_wr = 1'b0;
    rchk("R9 set wins over clear", 2, 32'h1);
    rchk("R9 counter wrapped", 9, 32'd0);

    // R10: interrupt combination
    wr(3, 32'hFF);
    rchk("R10 ie width", 3, 32'h3F);
    irq_chk("R10 irq flag0 enabled", 1'b1);
    wr(3, 32'h20);
    irq_chk("R10 irq ie bit5 only", 1'b0);
    wr(3, 32'h01);
    wr(0, 32'h042);
    irq_chk("R10 irq enable off", 1'b0);
    wr(0, 32'h041);
    irq_chk("R10 irq enable on", 1'b1);
    wr(2, 32'h1);
    irq_chk("R10 irq after clear", 1'b0);
    wr(3, 32'h0);

    // R8: free-run through compare and rollover
    wr(0, 32'h042);
    wr(4, 32'd10);
    wr(0, 32'h243);
    wr(2, 32'h21);
    for (int k = 1; k <= 260; k++) begin
      ticks(0, 1);
      if (k == 10) begin
        rchk("R8 at compare", 9, 32'd10);
        rchk("R8 no flag at compare", 2, 32'h0);
      end
      if (k == 11) begin
        rchk("R8 passes compare", 9, 32'd11);
        rchk("R8 compare flag", 2, 32'h1);
        wr(2, 32'h1);
      end
      if (k == 255) begin
        rchk("R8 all ones", 9, 32'd255);
        rchk("R8 no rollover yet", 2, 32'h0);
      end
      if (k == 256) begin
        rchk("R8 wrap to zero", 9, 32'd0);
        rchk("R8 rollover flag", 2, 32'h20);
      end
    end
    rchk("R8 after wrap", 9, 32'd4);
    wr(2, 32'h21);

    // R11: enable mode
    wr(0, 32'h242);
    ticks(0, 3);
    rchk("R11 hold when disabled", 9, 32'd4);
    wr(0, 32'h241);
    rchk("R11 resume keeps value", 9, 32'd4);
    ticks(0, 2);
    rchk("R11 resume counts", 9, 32'd6);
    wr(0, 32'h240);
    wr(0, 32'h243);
    rchk("R11 restart to zero", 9, 32'd0);
    ticks(0, 1);
    rchk("R11 restart counts", 9, 32'd1);

    // R12: soft reset
    wr(0, 32'h25F);
    ticks(0, 10);
    rchk("R12 pre flag set", 2, 32'h1);
    wr(1, 32'd3);
    wr(3, 32'h21);
    irq_chk("R12 irq before", 1'b1);
    wr(0, 32'h8000);
    rchk("R12 ctrl kept bits", 0, 32'h242);
    rchk("R12 prescaler", 1, 32'h0);
    rchk("R12 status", 2, 32'h0);
    rchk("R12 ie", 3, 32'h0);
    rchk("R12 compare", 4, 32'hFF);
    rchk("R12 counter", 9, 32'h0);
    irq_chk("R12 irq", 1'b0);
    wr(0, 32'h241);
    ticks(0, 3);
    rchk("R12 counts after soft reset", 9, 32'd3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule